// File: doc/BRIEF.md
# Quad codec control-port command decoder

This block is the device-side command decoder behind the serial control port of a four-channel telephony codec. An SPI-style slave front end, which is outside this block, delivers each 8-bit frame as a one-cycle strobe with its byte. The decoder treats a byte with its top bit set as a command and the next frame as that command's data. When the data frame arrives, the decoder applies the pair to one of three register classes. The first class holds codec setup: shared companding and frame-delay flags, plus per-channel path power and timeslot numbers. The second holds the 14-bit gain coefficients for each channel's transmit and receive paths, written one 7-bit half at a time. The third holds the subscriber-line interface pins of each channel: two bidirectional pins with a direction control each, and three output-only pins.

A line-interface command also sets up a status byte. The front end shifts this byte out during the data frame that follows. The status packs the pin levels of the addressed channel in reversed bit order, then the IO0 level of channels 1 to 3. A pin set as an input reports its external level. A pin set as an output reports the value last written to it.

Every register drives an output port, so the surrounding chip can use the settings directly.

Top module: `qcc_ctl_decoder`

## Requirements
- R1: After a synchronous reset all configuration, power, timeslot, gain and pin-output registers are zero. Both bidirectional pins of every channel are inputs (direction bits all 1). The status byte is zero and no command is pending.
- R2: While no command is pending, a received byte with bit 7 clear is discarded. The next byte is then decoded as a command.
- R3: A command byte changes no register. The frame after it is its data byte, and the register update is visible in the cycle after that data frame is received.
- R4: A command with bit 6 clear is a codec command. Its bit 5 (1 = A-law, 0 = mu-law) and bit 4 (delay mode) update the shared flags whatever channel bits 3:2 select.
- R5: In a codec command for channel bits 3:2, bit 0 powers up the receive path and stores the data byte as the receive timeslot. Bit 1 powers up the transmit path and stores the data byte as the transmit timeslot. With both bits set, both paths are updated.
- R6: A codec command with bits 1:0 both zero powers down both paths of its channel. Its data byte is discarded and the timeslots keep their values.
- R7: A command with bit 6 set is a gain command when bit 4 is 0 and a line-interface command when bit 4 is 1. The channel is given by bits 3:2.
- R8: In a gain command, bit 1 selects the transmit (1) or receive (0) coefficient. Bit 0 selects the low half [6:0] (0) or the high half [13:7] (1). Data bits 6:0 are stored into that half, data bit 7 is dropped, and the other half keeps its value.
- R9: In a line-interface command, bits 1:0 set the directions of IO1 and IO0 (1 = input). The data byte bits 4:2 drive O4..O2 and bits 1:0 drive IO1..IO0.
- R10: One cycle after a line-interface command frame, the status byte holds {IO0, IO1, O2, O3, O4} of the addressed channel in bits 7..3 and IO0 of channels 1, 2 and 3 in bits 2, 1 and 0. The values are those from before the pair is applied. The byte holds until the next frame and returns to zero after any other frame.
- R11: In the status byte, a bidirectional pin set as input reports its external level, and one set as output reports the value last written to it, for the addressed channel and for the cross-channel bits alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a frame byte has been received |
| rx_byte | input | 8 | Received frame byte |
| io0_pin | input | NCH | External level of IO0, one bit per channel |
| io1_pin | input | NCH | External level of IO1, one bit per channel |
| alaw_sel | output | 1 | Shared companding flag, 1 = A-law |
| delay_sel | output | 1 | Shared frame-delay flag |
| pwr_tx | output | NCH | Transmit path powered, per channel |
| pwr_rx | output | NCH | Receive path powered, per channel |
| tx_slot | output | NCH*8 | Transmit timeslots, channel c at [c*8 +: 8] |
| rx_slot | output | NCH*8 | Receive timeslots, channel c at [c*8 +: 8] |
| gain_tx | output | NCH*14 | Transmit gain coefficients, channel c at [c*14 +: 14] |
| gain_rx | output | NCH*14 | Receive gain coefficients, channel c at [c*14 +: 14] |
| pin_dir | output | NCH*2 | Pin directions {IO1, IO0}, channel c at [c*2 +: 2], 1 = input |
| pin_out | output | NCH*5 | Pin drive values {O4, O3, O2, IO1, IO0}, channel c at [c*5 +: 5] |
| tx_byte | output | 8 | Status byte for the next outgoing frame |

## Verification
A pairing state that has slipped by one frame shows at once: the next data byte lands in a register as a command would, or the next command is lost, and the register outputs disagree from the cycle after that frame. A wrong channel or class decode moves a value to another channel's slice or register group within one cycle of the data frame. Directions or drive values that are stored wrongly stay hidden until a status byte is requested. That byte then shows a swapped bit one cycle after the command frame, including through the cross-channel bits when another channel's pin is the faulty one.

// File: rtl/qcc_ctl_pkg.sv
package qcc_ctl_pkg;
  localparam int MAXCH  = 4;
  localparam int SLOT_W = 8;
  localparam int PIN_W  = 5;
  localparam int DIR_W  = 2;

  typedef enum logic [1:0] {CLS_CODEC, CLS_GAIN, CLS_SLIC} cmd_cls_e;

  // Class decode of a command byte (bit 6, then bit 4)
  function automatic cmd_cls_e classify(input logic [7:0] b);
    if (!b[6])     return CLS_CODEC;
    else if (b[4]) return CLS_SLIC;
    else           return CLS_GAIN;
  endfunction
endpackage

// File: rtl/qcc_frame_pair.sv
module qcc_frame_pair (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       cmd_stb,
  output logic       exec_stb,
  output logic [7:0] cmd_q
);
  logic pending;

  assign cmd_stb  = rx_valid && !pending && rx_byte[7];
  assign exec_stb = rx_valid && pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      cmd_q   <= '0;
    end else if (cmd_stb) begin
      pending <= 1'b1;
      cmd_q   <= rx_byte;
    end else if (exec_stb) begin
      pending <= 1'b0;
    end
  end

  // R3
  pair_close_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && pending) |=> !pending);
  // R2
  stray_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !pending && !rx_byte[7]) |=> !pending);
endmodule

// File: rtl/qcc_codec_regs.sv
module qcc_codec_regs
  import qcc_ctl_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  exec_stb,
  input  logic [7:0]            cmd,
  input  logic [7:0]            data,
  output logic                  alaw_sel,
  output logic                  delay_sel,
  output logic [NCH-1:0]        pwr_tx,
  output logic [NCH-1:0]        pwr_rx,
  output logic [NCH*SLOT_W-1:0] tx_slot,
  output logic [NCH*SLOT_W-1:0] rx_slot
);
  logic is_codec;
  assign is_codec = exec_stb && (classify(cmd) == CLS_CODEC);

  always_ff @(posedge clk) begin
    if (rst) begin
      alaw_sel  <= 1'b0;
      delay_sel <= 1'b0;
    end else if (is_codec) begin
      alaw_sel  <= cmd[5];
      delay_sel <= cmd[4];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic              hit;
    logic [SLOT_W-1:0] ts_tx, ts_rx;
    assign hit = is_codec && (cmd[3:2] == 2'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        pwr_tx[c] <= 1'b0;
        pwr_rx[c] <= 1'b0;
        ts_tx     <= '0;
        ts_rx     <= '0;
      end else if (hit) begin
        if (cmd[1:0] == 2'b00) begin
          pwr_tx[c] <= 1'b0;
          pwr_rx[c] <= 1'b0;
        end else begin
          if (cmd[0]) begin
            pwr_rx[c] <= 1'b1;
            ts_rx     <= data;
          end
          if (cmd[1]) begin
            pwr_tx[c] <= 1'b1;
            ts_tx     <= data;
          end
        end
      end
    end
    assign tx_slot[c*SLOT_W +: SLOT_W] = ts_tx;
    assign rx_slot[c*SLOT_W +: SLOT_W] = ts_rx;

    // R6
    pwr_down_chk: assert property (@(posedge clk) disable iff (rst)
      (hit && cmd[1:0] == 2'b00) |=> (!pwr_tx[c] && !pwr_rx[c] && $stable(ts_tx) && $stable(ts_rx)));
  end
endmodule

// File: rtl/qcc_gain_regs.sv
module qcc_gain_regs
  import qcc_ctl_pkg::*;
#(
  parameter int NCH = 4,
  parameter int GW  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec_stb,
  input  logic [7:0]        cmd,
  input  logic [7:0]        data,
  output logic [NCH*GW-1:0] gain_tx,
  output logic [NCH*GW-1:0] gain_rx
);
  localparam int HW = GW / 2;

  logic                  is_gain;
  logic [2*NCH*HW-1:0]   hi_all;
  assign is_gain = exec_stb && (classify(cmd) == CLS_GAIN);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [GW-1:0] coef_tx, coef_rx;
    logic          hit;
    assign hit = is_gain && (cmd[3:2] == 2'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        coef_tx <= '0;
        coef_rx <= '0;
      end else if (hit) begin
        if (cmd[1]) begin
          if (cmd[0]) coef_tx[GW-1:HW] <= data[HW-1:0];
          else        coef_tx[HW-1:0]  <= data[HW-1:0];
        end else begin
          if (cmd[0]) coef_rx[GW-1:HW] <= data[HW-1:0];
          else        coef_rx[HW-1:0]  <= data[HW-1:0];
        end
      end
    end
    assign gain_tx[c*GW +: GW] = coef_tx;
    assign gain_rx[c*GW +: GW] = coef_rx;
    assign hi_all[2*c*HW +: 2*HW] = {coef_tx[GW-1:HW], coef_rx[GW-1:HW]};
  end

  // R8
  low_half_only_chk: assert property (@(posedge clk) disable iff (rst)
    (is_gain && !cmd[0]) |=> $stable(hi_all));
endmodule

// File: rtl/qcc_slic_port.sv
module qcc_slic_port
  import qcc_ctl_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_valid,
  input  logic [7:0]           rx_byte,
  input  logic                 cmd_stb,
  input  logic                 exec_stb,
  input  logic [7:0]           cmd,
  input  logic [7:0]           data,
  input  logic [NCH-1:0]       io0_pin,
  input  logic [NCH-1:0]       io1_pin,
  output logic [NCH*DIR_W-1:0] pin_dir,
  output logic [NCH*PIN_W-1:0] pin_out,
  output logic [7:0]           tx_byte
);
  logic             is_slic;
  logic [MAXCH-1:0] e0, e1;
  logic [PIN_W-1:0] drv [MAXCH];
  logic [1:0]       sel;
  logic [7:0]       status;

  assign is_slic = exec_stb && (classify(cmd) == CLS_SLIC);

  for (genvar c = 0; c < MAXCH; c++) begin : g_ch
    if (c < NCH) begin : g_live
      logic [DIR_W-1:0] dir;
      logic [PIN_W-1:0] out;
      logic             hit;
      assign hit = is_slic && (cmd[3:2] == 2'(c));

      always_ff @(posedge clk) begin
        if (rst) begin
          dir <= '1;
          out <= '0;
        end else if (hit) begin
          dir <= cmd[1:0];
          out <= data[PIN_W-1:0];
        end
      end
      assign pin_dir[c*DIR_W +: DIR_W] = dir;
      assign pin_out[c*PIN_W +: PIN_W] = out;
      assign e0[c]  = dir[0] ? io0_pin[c] : out[0];
      assign e1[c]  = dir[1] ? io1_pin[c] : out[1];
      assign drv[c] = out;
    end else begin : g_pad
      assign e0[c]  = 1'b0;
      assign e1[c]  = 1'b0;
      assign drv[c] = '0;
    end
  end

  assign sel    = rx_byte[3:2];
  assign status = {e0[sel], e1[sel], drv[sel][2], drv[sel][3], drv[sel][4],
                   e0[1], e0[2], e0[3]};

  always_ff @(posedge clk) begin
    if (rst)                                             tx_byte <= '0;
    else if (cmd_stb && classify(rx_byte) == CLS_SLIC)  tx_byte <= status;
    else if (rx_valid)                                   tx_byte <= '0;
  end

  // R10
  status_clear_chk: assert property (@(posedge clk) disable iff (rst)
    exec_stb |=> (tx_byte == 8'h00));
  // R10
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> $stable(tx_byte));
endmodule

// File: rtl/qcc_ctl_decoder.sv
module qcc_ctl_decoder
  import qcc_ctl_pkg::*;
#(
  parameter int NCH = 4,
  parameter int GW  = 14
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rx_valid,
  input  logic [7:0]            rx_byte,
  input  logic [NCH-1:0]        io0_pin,
  input  logic [NCH-1:0]        io1_pin,
  output logic                  alaw_sel,
  output logic                  delay_sel,
  output logic [NCH-1:0]        pwr_tx,
  output logic [NCH-1:0]        pwr_rx,
  output logic [NCH*SLOT_W-1:0] tx_slot,
  output logic [NCH*SLOT_W-1:0] rx_slot,
  output logic [NCH*GW-1:0]     gain_tx,
  output logic [NCH*GW-1:0]     gain_rx,
  output logic [NCH*DIR_W-1:0]  pin_dir,
  output logic [NCH*PIN_W-1:0]  pin_out,
  output logic [7:0]            tx_byte
);
  logic       cmd_stb, exec_stb;
  logic [7:0] cmd_q;

  qcc_frame_pair u_pair (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .cmd_stb(cmd_stb), .exec_stb(exec_stb), .cmd_q(cmd_q)
  );

  qcc_codec_regs #(.NCH(NCH)) u_codec (
    .clk(clk), .rst(rst), .exec_stb(exec_stb), .cmd(cmd_q), .data(rx_byte),
    .alaw_sel(alaw_sel), .delay_sel(delay_sel), .pwr_tx(pwr_tx), .pwr_rx(pwr_rx),
    .tx_slot(tx_slot), .rx_slot(rx_slot)
  );

  qcc_gain_regs #(.NCH(NCH), .GW(GW)) u_gain (
    .clk(clk), .rst(rst), .exec_stb(exec_stb), .cmd(cmd_q), .data(rx_byte),
    .gain_tx(gain_tx), .gain_rx(gain_rx)
  );

  qcc_slic_port #(.NCH(NCH)) u_slic (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .cmd_stb(cmd_stb), .exec_stb(exec_stb), .cmd(cmd_q), .data(rx_byte),
    .io0_pin(io0_pin), .io1_pin(io1_pin),
    .pin_dir(pin_dir), .pin_out(pin_out), .tx_byte(tx_byte)
  );

  // R3
  cmd_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |=> ($stable(tx_slot) && $stable(rx_slot) && $stable(gain_tx) &&
                 $stable(gain_rx) && $stable(pin_out) && $stable(pin_dir)));
endmodule

// File: tb/tb_qcc_ctl_decoder.sv
module tb_qcc_ctl_decoder;
  localparam int NCH = 4;
  localparam int GW  = 14;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            rx_valid = 1'b0;
  logic [7:0]      rx_byte = '0;
  logic [NCH-1:0]  io0_pin = 4'b1010;
  logic [NCH-1:0]  io1_pin = 4'b0110;
  logic            alaw_sel, delay_sel;
  logic [NCH-1:0]  pwr_tx, pwr_rx;
  logic [NCH*8-1:0]  tx_slot, rx_slot;
  logic [NCH*GW-1:0] gain_tx, gain_rx;
  logic [NCH*2-1:0]  pin_dir;
  logic [NCH*5-1:0]  pin_out;
  logic [7:0]        tx_byte;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  qcc_ctl_decoder #(.NCH(NCH), .GW(GW)) dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .io0_pin(io0_pin), .io1_pin(io1_pin),
    .alaw_sel(alaw_sel), .delay_sel(delay_sel), .pwr_tx(pwr_tx), .pwr_rx(pwr_rx),
    .tx_slot(tx_slot), .rx_slot(rx_slot), .gain_tx(gain_tx), .gain_rx(gain_rx),
    .pin_dir(pin_dir), .pin_out(pin_out), .tx_byte(tx_byte)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Drive one frame; returns after the edge that consumed it
  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_byte  = 8'h00;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 flags", {alaw_sel, delay_sel, pwr_tx, pwr_rx}, 0);
    check("R1 slots", {tx_slot, rx_slot}, 0);
    check("R1 gains", gain_tx | gain_rx, 0);
    check("R1 pin_dir", pin_dir, 8'hFF);
    check("R1 pin_out/status", {pin_out, tx_byte}, 0);
  endtask

  task automatic t_stray;
    send(8'h12);
    send(8'h81);
    send(8'h09);
    check("R2 rx slot ch0", rx_slot[7:0], 8'h09);
    check("R2 rx power ch0", pwr_rx, 4'b0001);
  endtask

  task automatic t_pair;
    send(8'h86);
    check("R3 no write on command", {pwr_tx, tx_slot[15:8]}, 0);
    send(8'h15);
    check("R5 tx slot ch1", tx_slot[15:8], 8'h15);
    check("R5 tx power ch1", pwr_tx, 4'b0010);
  endtask

  task automatic t_global;
    send(8'hB9);
    send(8'h20);
    check("R4 flags from ch2 cmd", {alaw_sel, delay_sel}, 2'b11);
    check("R5 rx slot ch2", rx_slot[23:16], 8'h20);
    send(8'h9F);
    send(8'h03);
    check("R4 flags from ch3 cmd", {alaw_sel, delay_sel}, 2'b01);
    check("R5 both slots ch3", {tx_slot[31:24], rx_slot[31:24]}, 16'h0303);
    check("R5 both powers ch3", {pwr_tx[3], pwr_rx[3]}, 2'b11);
  endtask

  task automatic t_pdown;
    send(8'h84);
    send(8'h55);
    check("R6 ch1 powered down", {pwr_tx[1], pwr_rx[1]}, 2'b00);
    check("R6 ch1 slot kept", tx_slot[15:8], 8'h15);
    check("R6 other channels kept", {pwr_tx, pwr_rx}, 8'b1000_1101);
  endtask

  task automatic t_gain;
    send(8'hC6);
    send(8'hFF);
    check("R8 tx low half, bit7 dropped", gain_tx[GW +: GW], 14'h007F);
    send(8'hC7);
    send(8'h14);
    check("R8 tx high half", gain_tx[GW +: GW], 14'h0A7F);
    check("R8 rx ch1 untouched", gain_rx[GW +: GW], 14'h0000);
    send(8'hCD);
    send(8'h0D);
    check("R7 R8 rx high ch3", gain_rx[3*GW +: GW], 14'h0680);
    check("R7 gain cmd leaves slots", rx_slot[31:24], 8'h03);
  endtask

  task automatic t_slic;
    send(8'hD1);
    check("R10 status after reset dirs", tx_byte, 8'h05);
    @(negedge clk);
    check("R10 status held", tx_byte, 8'h05);
    send(8'h1E);
    check("R10 status cleared after data", tx_byte, 8'h00);
    check("R9 ch0 outputs", pin_out[4:0], 5'h1E);
    check("R9 ch0 dirs", pin_dir, 8'hFD);
    send(8'hD1);
    check("R11 output pin reads written value", tx_byte, 8'h7D);
    send(8'h1E);
    send(8'hD4);
    check("R10 R11 ch1 inputs", tx_byte, 8'hC5);
    send(8'h00);
    check("R9 ch1 now outputs", pin_dir, 8'hF1);
    send(8'hD1);
    check("R11 cross-channel output pin", tx_byte, 8'h79);
    send(8'h1E);
    send(8'h85);
    check("R10 status zero after codec cmd", tx_byte, 8'h00);
    send(8'h00);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all R): actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset;
    t_stray;
    t_pair;
    t_global;
    t_pdown;
    t_gain;
    t_slic;
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule